// File: doc/BRIEF.md
# Packet Receive Handler with Length and Address Filtering

This block sits behind the demodulator's sync detector and turns the byte stream of one packet into writes to a receive FIFO. Once it is armed it waits for a sync indication. It then reads the header bytes according to one of three length policies: a fixed length taken from configuration, a length byte sent in the packet, or a length byte with an upper bound. It can compare an address byte against a configured value. Packets that fail the length bound or the address compare are dropped as soon as the offending byte arrives. It can append two status bytes after the payload, and it can flush the FIFO when the CRC fails.

Two status lines go to the host. `pkt_active` is high from sync until the packet ends, is rejected or overflows. `crc_good` reports a packet that completed with a correct CRC and stays up until the host first reads the FIFO. The byte stream from the demodulator cannot be back-pressured. The FIFO side is a valid/ready-style write port whose ready is `!fifo_full`. A byte that would be written while `fifo_full` is high is not written. Instead the handler enters a sticky overflow state that only a flush request clears. `fifo_wr_drop` tells the FIFO to discard the uncommitted bytes of the current packet. `fifo_wr_last` marks the byte that completes it.

Top module: `pkt_rx_filter`

## Requirements
- R1: `pkt_active` rises in the cycle after `sync_detected` is taken in the search state and falls in the cycle after `crc_done` ends the packet.
- R2: With `cfg_len_mode` 2'b01 or 2'b11 (variable), the first byte after sync is a length byte that is written to the FIFO and counts the bytes that follow it. The address, when checked, is the second byte.
- R3: With `cfg_len_mode` 2'b00 (fixed), there is no length byte. Exactly `cfg_pkt_len` bytes are written, and the first of them is the address when checking is on.
- R4: With `cfg_addr_en` high, an address byte unequal to `cfg_addr` is not written. `fifo_wr_drop` pulses in that byte's cycle, `pkt_active` is low from the next cycle, and the handler returns to search whatever the value of `cfg_eop_search`.
- R5: With `cfg_len_mode` 2'b10 (bounded), a length byte greater than `cfg_pkt_len` is rejected in the same way as in R4, in its own cycle. A length equal to the bound is accepted.
- R6: A byte offered while `fifo_full` is high is not written, and `pkt_active` falls. `sync_detected` and `rx_start` are then ignored until `flush_req`, which pulses `fifo_flush` and returns to idle.
- R7: With `cfg_append_status` high, two bytes follow the payload on consecutive cycles after `crc_done`: first `stat_a`, then `{crc_ok, stat_b}`. `fifo_wr_last` is high only on the final byte written for an accepted packet.
- R8: `crc_good` goes high the cycle after `crc_done` with `crc_ok` high, and goes low the cycle after `fifo_rd`.
- R9: With `cfg_crc_autoflush` high, a `crc_done` with `crc_ok` low pulses `fifo_flush` in that cycle, and no status bytes are written.
- R10: `flush_req` produces a `fifo_flush` pulse in the same cycle only in the idle or overflow state. In every other state it has no effect.
- R11: `rx_start` moves idle to search. At the end of a packet the handler goes to search when `cfg_eop_search` is high and to idle when it is low.
- R12: Accepted bytes appear on `fifo_wr_data` with `fifo_wr_valid` in the same cycle as `in_valid`, in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_mode | input | 2 | 00 fixed, 01/11 variable, 10 bounded |
| cfg_pkt_len | input | 8 | Fixed length, or upper bound in bounded mode |
| cfg_addr_en | input | 1 | Enable address compare |
| cfg_addr | input | 8 | Address to match |
| cfg_append_status | input | 1 | Append two status bytes |
| cfg_crc_autoflush | input | 1 | Flush FIFO on CRC failure |
| cfg_eop_search | input | 1 | After a packet: 1 search, 0 idle |
| rx_start | input | 1 | Arm reception from idle |
| sync_detected | input | 1 | Sync word seen |
| in_valid | input | 1 | Demodulated byte present |
| in_data | input | 8 | Demodulated byte |
| crc_done | input | 1 | CRC result pulse at packet end |
| crc_ok | input | 1 | CRC result, valid with crc_done |
| stat_a | input | 8 | First status byte value |
| stat_b | input | 7 | Low bits of second status byte |
| fifo_full | input | 1 | FIFO cannot take a byte (not ready) |
| fifo_rd | input | 1 | Host read strobe on the FIFO |
| flush_req | input | 1 | Flush request strobe |
| fifo_wr_valid | output | 1 | Write a byte this cycle |
| fifo_wr_data | output | 8 | Byte to write |
| fifo_wr_last | output | 1 | Byte completes the packet |
| fifo_wr_drop | output | 1 | Discard the current packet's bytes |
| fifo_flush | output | 1 | Empty the whole FIFO |
| pkt_active | output | 1 | Sync seen, packet in progress |
| crc_good | output | 1 | Last packet ended with good CRC |

## Verification
A table of packets exercises the main path under each length policy: plain variable length, variable with a matching and a mismatching address, fixed length with both address outcomes, bounded length at and just over the bound, bounded with a bad address, and CRC failure with and without auto-flush. Together these separate where the address byte is taken from, whether the verdict lands on the right byte, and how status bytes and the last marker move with the CRC result. Write counts, drop and flush pulses, the written data and `crc_good` are compared after each packet. Directed sequences then probe the timing of `pkt_active`, the choice of next state at packet end and after a rejection, flush requests in states that must ignore them, and the sticky overflow state.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  localparam logic [1:0] LM_FIXED = 2'b00;
  localparam logic [1:0] LM_VAR   = 2'b01;
  localparam logic [1:0] LM_MAX   = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_PKT,
    ST_CRC,
    ST_STAT0,
    ST_STAT1,
    ST_OVF
  } rx_state_e;

  typedef struct packed {
    logic is_len;
    logic len_reject;
    logic addr_reject;
  } hdr_verdict_t;

endpackage

// File: rtl/pkt_rx_hdr_check.sv
module pkt_rx_hdr_check
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic [1:0]        len_mode,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] limit,
  input  logic              addr_en,
  input  logic [DATA_W-1:0] addr,
  output hdr_verdict_t      verdict
);

  logic             has_len;
  logic [IDX_W-1:0] addr_pos;

  always_comb begin
    has_len  = (len_mode != LM_FIXED);
    // a length byte pushes the address one position later
    addr_pos = has_len ? IDX_W'(1) : '0;
    verdict.is_len      = has_len && (idx == '0);
    verdict.len_reject  = verdict.is_len && (len_mode == LM_MAX) && (data > limit);
    verdict.addr_reject = addr_en && (idx == addr_pos) && (data != addr);
  end

endmodule

// File: rtl/pkt_rx_len_ctr.sv
module pkt_rx_len_ctr #(
  parameter int LEN_W = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             remain_one
);

  localparam logic [IDX_W-1:0] IDX_SAT = '1;

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      remain <= '0;
    end else begin
      if (clear)
        idx <= '0;
      else if (step && idx != IDX_SAT)
        idx <= idx + 1'b1;
      if (load)
        remain <= load_val;
      else if (step && remain != '0)
        remain <= remain - 1'b1;
    end
  end

  assign remain_one = (remain == LEN_W'(1));

endmodule

// File: rtl/pkt_rx_flag.sv
module pkt_rx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 1'b0;
    else if (set)
      q <= 1'b1;
    else if (clr)
      q <= 1'b0;
  end

endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_len_mode,
  input  logic [DATA_W-1:0] cfg_pkt_len,
  input  logic              cfg_addr_en,
  input  logic [DATA_W-1:0] cfg_addr,
  input  logic              cfg_append_status,
  input  logic              cfg_crc_autoflush,
  input  logic              cfg_eop_search,
  input  logic              rx_start,
  input  logic              sync_detected,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              crc_done,
  input  logic              crc_ok,
  input  logic [DATA_W-1:0] stat_a,
  input  logic [DATA_W-2:0] stat_b,
  input  logic              fifo_full,
  input  logic              fifo_rd,
  input  logic              flush_req,
  output logic              fifo_wr_valid,
  output logic [DATA_W-1:0] fifo_wr_data,
  output logic              fifo_wr_last,
  output logic              fifo_wr_drop,
  output logic              fifo_flush,
  output logic              pkt_active,
  output logic              crc_good
);

  localparam int LEN_W = DATA_W;
  localparam int IDX_W = 2;

  rx_state_e        state, state_d;
  logic             ok_q, ok_d;
  logic             ctr_clear, ctr_load, ctr_step;
  logic [LEN_W-1:0] load_val;
  logic [IDX_W-1:0] idx;
  logic             remain_one;
  logic             good_set;
  logic             last_byte;
  rx_state_e        eop_next;
  hdr_verdict_t     verdict;

  pkt_rx_hdr_check #(.DATA_W(DATA_W), .IDX_W(IDX_W)) hdr_i (
    .len_mode (cfg_len_mode),
    .idx      (idx),
    .data     (in_data),
    .limit    (cfg_pkt_len),
    .addr_en  (cfg_addr_en),
    .addr     (cfg_addr),
    .verdict  (verdict)
  );

  pkt_rx_len_ctr #(.LEN_W(LEN_W), .IDX_W(IDX_W)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (ctr_clear),
    .load       (ctr_load),
    .load_val   (load_val),
    .step       (ctr_step),
    .idx        (idx),
    .remain_one (remain_one)
  );

  pkt_rx_flag good_i (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (good_set),
    .clr   (fifo_rd),
    .q     (crc_good)
  );

  assign eop_next = cfg_eop_search ? ST_SEARCH : ST_IDLE;

  always_comb begin
    state_d       = state;
    ok_d          = ok_q;
    fifo_wr_valid = 1'b0;
    fifo_wr_data  = in_data;
    fifo_wr_last  = 1'b0;
    fifo_wr_drop  = 1'b0;
    fifo_flush    = 1'b0;
    ctr_clear     = 1'b0;
    ctr_load      = 1'b0;
    ctr_step      = 1'b0;
    load_val      = in_data;
    good_set      = 1'b0;
    last_byte     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (flush_req)
          fifo_flush = 1'b1;
        else if (rx_start)
          state_d = ST_SEARCH;
      end
      ST_SEARCH: begin
        if (sync_detected) begin
          ctr_clear = 1'b1;
          if (cfg_len_mode == LM_FIXED) begin
            ctr_load = 1'b1;
            load_val = cfg_pkt_len;
            state_d  = (cfg_pkt_len == '0) ? ST_CRC : ST_PKT;
          end else begin
            state_d = ST_PKT;
          end
        end
      end
      ST_PKT: begin
        if (in_valid) begin
          if (verdict.len_reject || verdict.addr_reject) begin
            fifo_wr_drop = 1'b1;
            state_d      = ST_SEARCH;
          end else if (fifo_full) begin
            state_d = ST_OVF;
          end else begin
            fifo_wr_valid = 1'b1;
            ctr_step      = 1'b1;
            ctr_load      = verdict.is_len;
            last_byte     = verdict.is_len ? (in_data == '0) : remain_one;
            if (last_byte) begin
              fifo_wr_last = !cfg_append_status;
              state_d      = ST_CRC;
            end
          end
        end
      end
      ST_CRC: begin
        if (crc_done) begin
          ok_d     = crc_ok;
          good_set = crc_ok;
          if (!crc_ok && cfg_crc_autoflush) begin
            fifo_flush = 1'b1;
            state_d    = eop_next;
          end else if (cfg_append_status) begin
            state_d = ST_STAT0;
          end else begin
            state_d = eop_next;
          end
        end
      end
      ST_STAT0: begin
        if (fifo_full) begin
          state_d = ST_OVF;
        end else begin
          fifo_wr_valid = 1'b1;
          fifo_wr_data  = stat_a;
          state_d       = ST_STAT1;
        end
      end
      ST_STAT1: begin
        if (fifo_full) begin
          state_d = ST_OVF;
        end else begin
          fifo_wr_valid = 1'b1;
          fifo_wr_data  = {ok_q, stat_b};
          fifo_wr_last  = 1'b1;
          state_d       = eop_next;
        end
      end
      ST_OVF: begin
        if (flush_req) begin
          fifo_flush = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ok_q  <= 1'b0;
    end else begin
      state <= state_d;
      ok_q  <= ok_d;
    end
  end

  assign pkt_active = (state == ST_PKT) || (state == ST_CRC);

endmodule

// File: rtl/pkt_rx_filter_chk.sv
module pkt_rx_filter_chk
  import pkt_rx_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sync_detected,
  input logic      crc_done,
  input logic      flush_req,
  input logic      fifo_rd,
  input logic      fifo_full,
  input logic      fifo_wr_valid,
  input logic      fifo_wr_drop,
  input logic      fifo_flush,
  input logic      pkt_active,
  input logic      crc_good,
  input rx_state_e st
);

  // R6
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |-> !fifo_full);

  // R4
  drop_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_drop |-> (!fifo_wr_valid && !fifo_flush));

  // R4
  drop_ends_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_drop |=> !pkt_active);

  // R1
  active_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_active) |-> $past(sync_detected));

  // R8
  good_clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && !crc_done) |=> !crc_good);

  // R10
  flush_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> (flush_req || crc_done));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OVF && !flush_req) |=> (st == ST_OVF));

endmodule

bind pkt_rx_filter pkt_rx_filter_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_detected (sync_detected),
  .crc_done      (crc_done),
  .flush_req     (flush_req),
  .fifo_rd       (fifo_rd),
  .fifo_full     (fifo_full),
  .fifo_wr_valid (fifo_wr_valid),
  .fifo_wr_drop  (fifo_wr_drop),
  .fifo_flush    (fifo_flush),
  .pkt_active    (pkt_active),
  .crc_good      (crc_good),
  .st            (state)
);

// File: tb/pkt_rx_filter_tb_top.sv
`timescale 1ns/1ps
module pkt_rx_filter_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_len_mode;
  logic [7:0] cfg_pkt_len;
  logic       cfg_addr_en;
  logic [7:0] cfg_addr;
  logic       cfg_append_status;
  logic       cfg_crc_autoflush;
  logic       cfg_eop_search;
  logic       rx_start, sync_detected, in_valid;
  logic [7:0] in_data;
  logic       crc_done, crc_ok;
  logic [7:0] stat_a;
  logic [6:0] stat_b;
  logic       fifo_full, fifo_rd, flush_req;
  logic       fifo_wr_valid;
  logic [7:0] fifo_wr_data;
  logic       fifo_wr_last, fifo_wr_drop, fifo_flush, pkt_active, crc_good;

  always #4 clk = ~clk;

  pkt_rx_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_len_mode(cfg_len_mode), .cfg_pkt_len(cfg_pkt_len),
    .cfg_addr_en(cfg_addr_en), .cfg_addr(cfg_addr),
    .cfg_append_status(cfg_append_status), .cfg_crc_autoflush(cfg_crc_autoflush),
    .cfg_eop_search(cfg_eop_search), .rx_start(rx_start),
    .sync_detected(sync_detected), .in_valid(in_valid), .in_data(in_data),
    .crc_done(crc_done), .crc_ok(crc_ok), .stat_a(stat_a), .stat_b(stat_b),
    .fifo_full(fifo_full), .fifo_rd(fifo_rd), .flush_req(flush_req),
    .fifo_wr_valid(fifo_wr_valid), .fifo_wr_data(fifo_wr_data),
    .fifo_wr_last(fifo_wr_last), .fifo_wr_drop(fifo_wr_drop),
    .fifo_flush(fifo_flush), .pkt_active(pkt_active), .crc_good(crc_good)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // write logger, samples one ns before each rising edge
  logic       log_clr = 1'b0;
  int         n_wr, n_last, n_drop, n_flush;
  logic [7:0] log_d [32];

  always @(negedge clk) begin
    #3;
    if (log_clr) begin
      n_wr = 0; n_last = 0; n_drop = 0; n_flush = 0;
    end else begin
      if (fifo_wr_valid) begin
        if (n_wr < 32) log_d[n_wr] = fifo_wr_data;
        n_wr++;
        if (fifo_wr_last) n_last++;
      end
      if (fifo_wr_drop) n_drop++;
      if (fifo_flush)   n_flush++;
    end
  end

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] lim;
    logic       aen;
    logic [7:0] addr;
    logic       app;
    logic       af;
    logic       ok;
    logic [7:0] h0;
    logic [7:0] h1;
    logic [7:0] nsent;
    logic [7:0] ewr;
    logic       edrop;
    logic       eflush;
    logic       egood;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 8'h00, 1'b0, 8'h06, 1'b0, 1'b0, 1'b1, 8'h04, 8'h41, 8'd5,  8'd5,  1'b0, 1'b0, 1'b1},
    '{2'b01, 8'h00, 1'b1, 8'h06, 1'b1, 1'b0, 1'b1, 8'h03, 8'h06, 8'd4,  8'd6,  1'b0, 1'b0, 1'b1},
    '{2'b01, 8'h00, 1'b1, 8'h06, 1'b0, 1'b0, 1'b1, 8'h07, 8'h07, 8'd8,  8'd1,  1'b1, 1'b0, 1'b0},
    '{2'b00, 8'h03, 1'b1, 8'h06, 1'b0, 1'b0, 1'b1, 8'h06, 8'h41, 8'd3,  8'd3,  1'b0, 1'b0, 1'b1},
    '{2'b00, 8'h03, 1'b1, 8'h06, 1'b0, 1'b0, 1'b1, 8'h05, 8'h41, 8'd3,  8'd0,  1'b1, 1'b0, 1'b0},
    '{2'b10, 8'h0A, 1'b0, 8'h06, 1'b0, 1'b0, 1'b1, 8'h0A, 8'h41, 8'd11, 8'd11, 1'b0, 1'b0, 1'b1},
    '{2'b10, 8'h09, 1'b0, 8'h06, 1'b0, 1'b0, 1'b1, 8'h0A, 8'h41, 8'd11, 8'd0,  1'b1, 1'b0, 1'b0},
    '{2'b01, 8'h00, 1'b0, 8'h06, 1'b1, 1'b0, 1'b0, 8'h02, 8'h41, 8'd3,  8'd5,  1'b0, 1'b0, 1'b0},
    '{2'b01, 8'h00, 1'b0, 8'h06, 1'b1, 1'b1, 1'b0, 8'h02, 8'h41, 8'd3,  8'd3,  1'b0, 1'b1, 1'b0},
    '{2'b10, 8'h09, 1'b1, 8'h06, 1'b0, 1'b0, 1'b1, 8'h03, 8'h09, 8'd4,  8'd1,  1'b1, 1'b0, 1'b0}
  };

  function automatic string vec_tag(input int v);
    case (v)
      0: return "R2";
      1: return "R7";
      2: return "R4";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R5";
      7: return "R7";
      8: return "R9";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [7:0] pkt_byte(input vec_t t, input int i);
    if (i == 0) return t.h0;
    if (i == 1) return t.h1;
    return 8'h40 + 8'(i);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_rx_start();
    @(negedge clk); rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
  endtask
  task automatic pulse_sync();
    @(negedge clk); sync_detected = 1'b1; @(negedge clk); sync_detected = 1'b0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); fifo_rd = 1'b1; @(negedge clk); fifo_rd = 1'b0;
  endtask
  task automatic pulse_flush();
    @(negedge clk); flush_req = 1'b1; @(negedge clk); flush_req = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_data = b; @(negedge clk); in_valid = 1'b0;
  endtask
  task automatic send_crc(input logic ok);
    @(negedge clk); crc_done = 1'b1; crc_ok = ok; @(negedge clk); crc_done = 1'b0;
  endtask
  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
  endtask
  task automatic set_cfg(input logic [1:0] m, input logic [7:0] l, input logic aen,
                         input logic app, input logic af, input logic eop);
    cfg_len_mode = m; cfg_pkt_len = l; cfg_addr_en = aen; cfg_addr = 8'h06;
    cfg_append_status = app; cfg_crc_autoflush = af; cfg_eop_search = eop;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_start = 0; sync_detected = 0; in_valid = 0; in_data = 0;
    crc_done = 0; crc_ok = 0; fifo_full = 0; fifo_rd = 0; flush_req = 0;
    stat_a = 8'hC5; stat_b = 7'h2A;
    set_cfg(2'b01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset pkt_active", int'(pkt_active), 0);
    chk("R8 reset crc_good", int'(crc_good), 0);
    chk("R12 reset fifo_wr_valid", int'(fifo_wr_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // table of packets
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      int   exp_last;
      int   bad;
      t = VECS[v];
      set_cfg(t.mode, t.lim, t.aen, t.app, t.af, 1'b0);
      pulse_rd();
      clear_log();
      pulse_rx_start();
      pulse_sync();
      for (int i = 0; i < int'(t.nsent); i++) send_byte(pkt_byte(t, i));
      send_crc(t.ok);
      repeat (4) @(negedge clk);
      #1;
      exp_last = (t.ewr != 0 && !t.edrop && !t.eflush) ? 1 : 0;
      bad = 0;
      for (int k = 0; k < int'(t.ewr) && k < 32; k++) begin
        logic [7:0] e;
        if (k < int'(t.nsent)) e = pkt_byte(t, k);
        else if (k == int'(t.nsent)) e = stat_a;
        else e = {t.ok, stat_b};
        if (k < n_wr && log_d[k] != e) bad++;
      end
      $display("vector %0d (%s)", v, vec_tag(v));
      chk({vec_tag(v), " write count"}, n_wr, int'(t.ewr));
      chk({vec_tag(v), " drop pulses"}, n_drop, int'(t.edrop));
      chk("R9 flush pulses", n_flush, int'(t.eflush));
      chk("R7 last markers", n_last, exp_last);
      chk("R12 written data mismatches", bad, 0);
      chk("R8 crc_good after packet", int'(crc_good), int'(t.egood));
    end

    // R1 and R11: status timing, end state idle
    set_cfg(2'b01, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
    pulse_rx_start();
    pulse_sync(); #1;
    chk("R1 pkt_active after sync", int'(pkt_active), 1);
    send_byte(8'h02); send_byte(8'h11); send_byte(8'h12); #1;
    chk("R1 pkt_active before crc", int'(pkt_active), 1);
    send_crc(1'b1); #1;
    chk("R1 pkt_active after crc_done", int'(pkt_active), 0);
    chk("R8 crc_good set", int'(crc_good), 1);
    pulse_rd(); #1;
    chk("R8 crc_good cleared by read", int'(crc_good), 0);
    pulse_sync(); #1;
    chk("R11 idle ignores sync", int'(pkt_active), 0);

    // R11: end state search
    cfg_eop_search = 1'b1;
    pulse_rx_start();
    pulse_sync();
    send_byte(8'h01); send_byte(8'h21);
    send_crc(1'b1);
    pulse_sync(); #1;
    chk("R11 search after packet", int'(pkt_active), 1);
    send_byte(8'h00);
    send_crc(1'b1);
    cfg_eop_search = 1'b0;

    // R4: rejection returns to search even with idle configured
    cfg_addr_en = 1'b1;
    pulse_sync();
    send_byte(8'h05); send_byte(8'h07); #1;
    chk("R4 pkt_active low after bad address", int'(pkt_active), 0);
    pulse_sync(); #1;
    chk("R4 search after rejection", int'(pkt_active), 1);
    send_byte(8'h00);
    send_crc(1'b1);
    cfg_addr_en = 1'b0;

    // R10: flush ignored mid-packet, honoured in idle
    pulse_rx_start();
    pulse_sync();
    clear_log();
    pulse_flush(); #1;
    chk("R10 flush ignored in packet", n_flush, 0);
    chk("R10 packet continues", int'(pkt_active), 1);
    send_byte(8'h00);
    send_crc(1'b1);
    pulse_flush(); #1;
    chk("R10 flush in idle", n_flush, 1);

    // R6: overflow is sticky until flush
    clear_log();
    pulse_rx_start();
    pulse_sync();
    send_byte(8'h03);
    fifo_full = 1'b1;
    send_byte(8'h31);
    fifo_full = 1'b0; #1;
    chk("R6 pkt_active low on overflow", int'(pkt_active), 0);
    chk("R6 byte not written when full", n_wr, 1);
    pulse_sync(); #1;
    chk("R6 sync ignored in overflow", int'(pkt_active), 0);
    pulse_rx_start();
    pulse_sync(); #1;
    chk("R6 rx_start ignored in overflow", int'(pkt_active), 0);
    pulse_flush(); #1;
    chk("R6 flush leaves overflow", n_flush, 1);
    pulse_rx_start();
    pulse_sync(); #1;
    chk("R6 reception resumes after flush", int'(pkt_active), 1);
    send_byte(8'h00);
    send_crc(1'b1);
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule